// File: doc/BRIEF.md
# Cache Lock and Victim-Selection Controller

This controller sits beside the tag array of one four-way set-associative cache and decides, for every access, whether a miss may fill a line and which way that fill replaces. One copy serves the instruction cache and another serves the data cache, so each cache keeps its own lock settings. The tag and data arrays are outside the block. The tag lookup supplies the hit flag, the hit way, the set index and the valid bits of the addressed set in the same cycle. The controller answers combinationally in that cycle with an allocate flag, a cache-inhibited flag and a one-hot victim way.

Lock settings are captured when `cfg_load_i` pulses, and a three-state machine holds them. `LK_OPEN` means nothing is locked. `LK_PARTIAL` means ways 0 through N are locked, where N is the loaded 2-bit count. `LK_FROZEN` means the whole cache is locked. Every load re-decodes the settings, so every state can move to every state. `go_frozen` is taken when the whole-cache bit is set or when the way-lock count is 3. `go_partial` is taken when way locking is enabled with a count of 0 to 2. `go_open` is taken when neither is requested. While frozen, hits are served normally and misses go out as cache-inhibited without a fill. Lines that were invalid when the lock was set therefore stay invalid until the lock is released.

Each set keeps a 3-bit tree pseudo-LRU state. Any hit updates it, including a hit to a locked way. Any fill updates it as well.

Top module: `cache_lock_ctrl`

## Requirements
- R1: After reset the state is `LK_OPEN` and every set's pseudo-LRU bits are 0, so the first miss to a fully valid set picks way 0. With `acc_vld_i` low all three outputs are 0.
- R2: On a `cfg_load_i` pulse, the next cycle is frozen if the whole-cache bit is 1 or if way locking is enabled with count 3. If way locking is enabled with count N below 3, ways 0..N are locked. Otherwise nothing is locked.
- R3: A valid hit drives `alloc_o`=0, `inhibit_o`=0 and `victim_o`=0 in every state.
- R4: While frozen, a valid miss drives `inhibit_o`=1, `alloc_o`=0 and `victim_o`=0.
- R5: While not frozen, a valid miss drives `alloc_o`=1, `inhibit_o`=0 and exactly one bit of `victim_o`, where bit i stands for way i.
- R6: If some unlocked way of the set is invalid (`acc_set_valid_i[i]`=0), the victim is the lowest-numbered such way.
- R7: Otherwise the victim comes from the tree bits {b2,b1,b0}. If b0=0 the left pair (ways 0 and 1) is taken, otherwise the right pair (ways 2 and 3). A pair with both ways locked is skipped. Within the left pair b1 selects way 0 (b1=0) or way 1. Within the right pair b2 selects way 2 (b2=0) or way 3. A locked choice falls to its sibling.
- R8: A hit or a fill to way w of set s updates that set at the clock edge and leaves other sets unchanged. For w=0 the update is b0=1, b1=1. For w=1 it is b0=1, b1=0. For w=2 it is b0=0, b2=1. For w=3 it is b0=0, b2=0. A frozen miss changes nothing.
- R9: A locked way is never the victim.
- R10: After an unlock load, lines left invalid during the frozen period are eligible for allocation again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Capture the lock settings this cycle |
| cfg_whole_lock_i | input | 1 | Whole-cache lock request |
| cfg_way_lock_en_i | input | 1 | Way locking enable |
| cfg_way_lock_cnt_i | input | 2 | Highest locked way N (ways 0..N) |
| acc_vld_i | input | 1 | Lookup result valid |
| acc_hit_i | input | 1 | Lookup hit |
| acc_hit_way_i | input | 2 | Way index of the hit |
| acc_set_i | input | SET_W | Set index |
| acc_set_valid_i | input | 4 | Valid bits of the addressed set |
| alloc_o | output | 1 | Miss may fill a line |
| inhibit_o | output | 1 | Miss is treated as cache-inhibited |
| victim_o | output | 4 | One-hot way to replace |

## Verification
Fully valid sets with no lock drive the plain tree walk. Interleaving hits makes the next victim shift in a way that only an update on hits explains. Sets with holes in the valid bits separate the invalid-first rule from the tree choice, and with locks applied they show that locked holes are skipped. Frozen phases combined with hits, with misses to empty sets and with a later unlock distinguish served hits, inhibited misses and the release of invalid lines. Random hit, miss and reload traffic over a few reused sets compares every cycle against a behavioural model of these rules.

// File: rtl/cache_lock_pkg.sv
package cache_lock_pkg;
    localparam int WAYS   = 4;
    localparam int WIDX_W = $clog2(WAYS);

    typedef enum logic [1:0] {
        LK_OPEN    = 2'd0,
        LK_PARTIAL = 2'd1,
        LK_FROZEN  = 2'd2
    } lk_state_e;

    typedef logic [WAYS-2:0] plru_t;
    typedef logic [WAYS-1:0] wmask_t;
endpackage

// File: rtl/cache_lock_fsm.sv
module cache_lock_fsm
    import cache_lock_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              whole_i,
    input  logic              way_en_i,
    input  logic [WIDX_W-1:0] way_cnt_i,
    output lk_state_e         state_o,
    output wmask_t            lock_mask_o
);
    localparam logic [WIDX_W-1:0] CNT_ILLEGAL = WIDX_W'(WAYS - 1);

    lk_state_e         state_q, state_d;
    logic [WIDX_W-1:0] cnt_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            if (whole_i || (way_en_i && way_cnt_i == CNT_ILLEGAL)) begin
                state_d = LK_FROZEN;       // go_frozen
            end else if (way_en_i) begin
                state_d = LK_PARTIAL;      // go_partial
            end else begin
                state_d = LK_OPEN;         // go_open
            end
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= LK_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) begin
                cnt_q <= way_cnt_i;
            end
        end
    end

    // outputs
    always_comb begin
        lock_mask_o = '0;
        unique case (state_q)
            LK_OPEN:    lock_mask_o = '0;
            LK_PARTIAL: begin
                for (int w = 0; w < WAYS; w++) begin
                    lock_mask_o[w] = (WIDX_W'(w) <= cnt_q);
                end
            end
            LK_FROZEN:  lock_mask_o = '1;
            default:    lock_mask_o = '1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/cache_lock_plru.sv
module cache_lock_plru
    import cache_lock_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SET_W-1:0]  rd_set_i,
    output plru_t             rd_bits_o,
    input  logic              upd_en_i,
    input  logic [SET_W-1:0]  upd_set_i,
    input  logic [WIDX_W-1:0] upd_way_i
);
    plru_t mem_q [NUM_SETS];
    plru_t touched;

    // point the tree away from the way just used
    always_comb begin
        touched = mem_q[upd_set_i];
        if (!upd_way_i[1]) begin
            touched[0] = 1'b1;
            touched[1] = ~upd_way_i[0];
        end else begin
            touched[0] = 1'b0;
            touched[2] = ~upd_way_i[0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                mem_q[s] <= '0;
            end
        end else if (upd_en_i) begin
            mem_q[upd_set_i] <= touched;
        end
    end

    assign rd_bits_o = mem_q[rd_set_i];
endmodule

// File: rtl/cache_lock_victim.sv
module cache_lock_victim
    import cache_lock_pkg::*;
(
    input  wmask_t            valid_i,
    input  wmask_t            lock_i,
    input  plru_t             tree_i,
    output logic [WIDX_W-1:0] idx_o
);
    wmask_t            free;
    logic              found;
    logic              left_ok, right_ok, go_right;
    logic [WIDX_W-1:0] pref;

    assign free = ~valid_i & ~lock_i;

    always_comb begin
        found    = 1'b0;
        idx_o    = '0;
        left_ok  = ~(lock_i[0] & lock_i[1]);
        right_ok = ~(lock_i[2] & lock_i[3]);
        go_right = (tree_i[0] && right_ok) || !left_ok;
        pref     = go_right ? {1'b1, tree_i[2]} : {1'b0, tree_i[1]};
        for (int w = 0; w < WAYS; w++) begin
            if (!found && free[w]) begin
                found = 1'b1;
                idx_o = WIDX_W'(w);
            end
        end
        if (!found) begin
            idx_o = lock_i[pref] ? (pref ^ WIDX_W'(1)) : pref;
        end
    end
endmodule

// File: rtl/cache_lock_ctrl.sv
module cache_lock_ctrl
    import cache_lock_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_load_i,
    input  logic             cfg_whole_lock_i,
    input  logic             cfg_way_lock_en_i,
    input  logic [1:0]       cfg_way_lock_cnt_i,
    input  logic             acc_vld_i,
    input  logic             acc_hit_i,
    input  logic [1:0]       acc_hit_way_i,
    input  logic [SET_W-1:0] acc_set_i,
    input  logic [3:0]       acc_set_valid_i,
    output logic             alloc_o,
    output logic             inhibit_o,
    output logic [3:0]       victim_o
);
    lk_state_e         state;
    wmask_t            lock_mask;
    plru_t             tree;
    logic [WIDX_W-1:0] vic_idx;
    logic              miss, frozen, upd_en;
    logic [WIDX_W-1:0] upd_way;

    cache_lock_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (cfg_load_i),
        .whole_i     (cfg_whole_lock_i),
        .way_en_i    (cfg_way_lock_en_i),
        .way_cnt_i   (cfg_way_lock_cnt_i),
        .state_o     (state),
        .lock_mask_o (lock_mask)
    );

    cache_lock_plru #(.NUM_SETS(NUM_SETS)) u_plru (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_set_i  (acc_set_i),
        .rd_bits_o (tree),
        .upd_en_i  (upd_en),
        .upd_set_i (acc_set_i),
        .upd_way_i (upd_way)
    );

    cache_lock_victim u_victim (
        .valid_i (acc_set_valid_i),
        .lock_i  (lock_mask),
        .tree_i  (tree),
        .idx_o   (vic_idx)
    );

    assign miss      = acc_vld_i && !acc_hit_i;
    assign frozen    = (state == LK_FROZEN);
    assign alloc_o   = miss && !frozen;
    assign inhibit_o = miss && frozen;
    assign victim_o  = alloc_o ? (4'b0001 << vic_idx) : 4'b0000;
    assign upd_en    = (acc_vld_i && acc_hit_i) || alloc_o;
    assign upd_way   = acc_hit_i ? acc_hit_way_i : vic_idx;
endmodule

// File: rtl/cache_lock_ctrl_chk.sv
module cache_lock_ctrl_chk
    import cache_lock_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cfg_load_i,
    input logic       cfg_whole_lock_i,
    input logic       cfg_way_lock_en_i,
    input logic       acc_vld_i,
    input logic       acc_hit_i,
    input logic [3:0] acc_set_valid_i,
    input logic       alloc_o,
    input logic       inhibit_o,
    input logic [3:0] victim_o,
    input lk_state_e  state,
    input wmask_t     lock_mask
);
    // R9
    victim_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_o |-> ((victim_o & lock_mask) == 4'b0000));

    // R4
    frozen_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_vld_i && !acc_hit_i && state == LK_FROZEN) |-> (inhibit_o && !alloc_o && victim_o == 4'b0000));

    // R3
    hit_served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_vld_i && acc_hit_i) |-> (!alloc_o && !inhibit_o && victim_o == 4'b0000));

    // R5
    victim_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_o |-> ($countones(victim_o) == 1));

    // R6
    invalid_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alloc_o && ((~acc_set_valid_i & ~lock_mask) != 4'b0000)) |-> ((victim_o & acc_set_valid_i) == 4'b0000));

    // R2
    whole_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_load_i && cfg_whole_lock_i) |=> (state == LK_FROZEN));

    // R2
    open_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_load_i && !cfg_whole_lock_i && !cfg_way_lock_en_i) |=> (lock_mask == 4'b0000));
endmodule

bind cache_lock_ctrl cache_lock_ctrl_chk u_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .cfg_load_i        (cfg_load_i),
    .cfg_whole_lock_i  (cfg_whole_lock_i),
    .cfg_way_lock_en_i (cfg_way_lock_en_i),
    .acc_vld_i         (acc_vld_i),
    .acc_hit_i         (acc_hit_i),
    .acc_set_valid_i   (acc_set_valid_i),
    .alloc_o           (alloc_o),
    .inhibit_o         (inhibit_o),
    .victim_o          (victim_o),
    .state             (state),
    .lock_mask         (lock_mask)
);

// File: tb/test_cache_lock_ctrl.sv
module test_cache_lock_ctrl;
    localparam int NUM_SETS = 128;
    localparam int SET_W    = $clog2(NUM_SETS);

    logic             clk_i = 1'b0;
    logic             rst_ni;
    logic             cfg_load_i, cfg_whole_lock_i, cfg_way_lock_en_i;
    logic [1:0]       cfg_way_lock_cnt_i;
    logic             acc_vld_i, acc_hit_i;
    logic [1:0]       acc_hit_way_i;
    logic [SET_W-1:0] acc_set_i;
    logic [3:0]       acc_set_valid_i;
    logic             alloc_o, inhibit_o;
    logic [3:0]       victim_o;

    always #4 clk_i = ~clk_i;

    cache_lock_ctrl #(.NUM_SETS(NUM_SETS)) i_cache_lock_ctrl (.*);

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference model: mode 0 open, 1 partial, 2 frozen
    bit [2:0] m_tree [NUM_SETS];
    int       m_mode = 0;
    int       m_cnt  = 0;
    bit       e_alloc, e_inh, e_by_hole;
    bit [3:0] e_vic;
    int       e_idx;

    function automatic bit is_locked(int w);
        return (m_mode == 2) || (m_mode == 1 && w <= m_cnt);
    endfunction

    task automatic predict();
        bit [2:0] b;
        bit       right;
        int       pick;
        e_alloc = 0; e_inh = 0; e_vic = 0; e_idx = -1; e_by_hole = 0;
        if (!acc_vld_i || acc_hit_i) return;
        if (m_mode == 2) begin e_inh = 1; return; end
        e_alloc = 1;
        for (int w = 0; w < 4; w++)
            if (e_idx < 0 && !is_locked(w) && !acc_set_valid_i[w]) e_idx = w;
        e_by_hole = (e_idx >= 0);
        if (e_idx < 0) begin
            b = m_tree[acc_set_i];
            right = b[0];
            if (is_locked(0) && is_locked(1)) right = 1;
            pick = right ? 2 + int'(b[2]) : int'(b[1]);
            if (is_locked(pick)) pick = pick ^ 1;
            e_idx = pick;
        end
        e_vic = 4'b0001 << e_idx;
    endtask

    task automatic touch(int s, int w);
        if (w < 2) begin m_tree[s][0] = 1; m_tree[s][1] = (w == 0); end
        else       begin m_tree[s][0] = 0; m_tree[s][2] = (w == 2); end
    endtask

    task automatic commit();
        if (acc_vld_i) begin
            if (acc_hit_i)    touch(int'(acc_set_i), int'(acc_hit_way_i));
            else if (e_alloc) touch(int'(acc_set_i), e_idx);
        end
        if (cfg_load_i) begin
            m_cnt = int'(cfg_way_lock_cnt_i);
            if (cfg_whole_lock_i || (cfg_way_lock_en_i && cfg_way_lock_cnt_i == 2'd3)) m_mode = 2;
            else if (cfg_way_lock_en_i) m_mode = 1;
            else m_mode = 0;
        end
    endtask

    // called just after a negedge with inputs driven
    task automatic step(string tag);
        string t;
        #2;
        predict();
        t = tag;
        if (t == "") begin
            if (!acc_vld_i)     t = "R1";
            else if (acc_hit_i) t = "R3";
            else if (e_inh)     t = "R4";
            else if (e_by_hole) t = "R6";
            else                t = "R7";
        end
        vectors++;
        if (alloc_o !== e_alloc || inhibit_o !== e_inh || victim_o !== e_vic) begin
            errors++;
            $display("FAIL %s: alloc/inhibit/victim = %0b/%0b/%b, expected %0b/%0b/%b",
                     t, alloc_o, inhibit_o, victim_o, e_alloc, e_inh, e_vic);
        end
        for (int w = 0; w < 4; w++) begin
            if (alloc_o === 1'b1 && victim_o[w] === 1'b1 && is_locked(w)) begin
                errors++;
                $display("FAIL R9: victim %b hits locked way %0d, expected an unlocked way", victim_o, w);
            end
        end
        commit();
        @(negedge clk_i);
    endtask

    task automatic idle();
        cfg_load_i = 0; cfg_whole_lock_i = 0; cfg_way_lock_en_i = 0; cfg_way_lock_cnt_i = 0;
        acc_vld_i = 0; acc_hit_i = 0; acc_hit_way_i = 0; acc_set_i = '0; acc_set_valid_i = 0;
    endtask

    task automatic access(bit hit, int way, int set, bit [3:0] vld);
        idle();
        acc_vld_i = 1; acc_hit_i = hit; acc_hit_way_i = 2'(way);
        acc_set_i = SET_W'(set); acc_set_valid_i = vld;
    endtask

    task automatic load(bit whole, bit en, int cnt);
        idle();
        cfg_load_i = 1; cfg_whole_lock_i = whole; cfg_way_lock_en_i = en;
        cfg_way_lock_cnt_i = 2'(cnt);
    endtask

    initial begin
        for (int s = 0; s < NUM_SETS; s++) m_tree[s] = 0;
        idle();
        rst_ni = 0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1;

        idle();                         step("R1");
        access(0, 0, 0, 4'b1111);       step("R1");   // way 0 after reset
        access(0, 0, 0, 4'b1111);       step("R7");   // right pair, way 2
        access(1, 1, 0, 4'b1111);       step("R3");
        access(0, 0, 0, 4'b1111);       step("R8");   // hit on way 1 steers to way 3
        access(0, 0, 1, 4'b1011);       step("R6");   // hole at way 2
        load(0, 1, 1);                  step("R2");   // ways 0,1 locked
        access(0, 0, 2, 4'b0000);       step("R9");   // holes at 0,1 locked -> way 2
        access(1, 0, 2, 4'b1111);       step("R3");   // hit on locked way
        access(0, 0, 4, 4'b1111);       step("R9");
        load(0, 1, 3);                  step("R2");   // count 3 means frozen
        access(0, 0, 3, 4'b0000);       step("R2");
        access(1, 2, 3, 4'b1111);       step("R3");
        access(0, 0, 5, 4'b0001);       step("R4");
        load(0, 0, 0);                  step("R2");
        access(0, 0, 3, 4'b0000);       step("R10");  // holes usable again
        load(1, 0, 0);                  step("R2");
        access(0, 0, 6, 4'b1111);       step("R4");

        for (int n = 0; n < 4000; n++) begin
            idle();
            if ($urandom_range(0, 99) < 5) begin
                cfg_load_i = 1;
                cfg_whole_lock_i = ($urandom_range(0, 3) == 0);
                cfg_way_lock_en_i = 1'($urandom_range(0, 1));
                cfg_way_lock_cnt_i = 2'($urandom_range(0, 3));
            end
            acc_vld_i = ($urandom_range(0, 9) < 8);
            acc_hit_i = ($urandom_range(0, 9) < 4);
            acc_hit_way_i = 2'($urandom_range(0, 3));
            acc_set_i = SET_W'($urandom_range(0, 3));
            acc_set_valid_i = ($urandom_range(0, 1) == 1) ? 4'b1111 : 4'($urandom_range(0, 15));
            step("");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule